// File: doc/BRIEF.md
# Zero-Suppressed Hierarchical Pixel Matrix Readout

This block reads out a matrix of pixel counters as one serial bit stream and leaves out every part of the matrix that holds no hits. Each pixel has a hit flag and a counter word. When a readout starts, the block takes a snapshot of all hit flags. It then walks the matrix and skips empty regions at three levels: a whole double column, a whole superpixel, or a single pixel.

Adjacent columns are paired into double columns. Each double column is cut into superpixels that are 2 columns wide and 8 rows tall. A superpixel counts as hit when any of its 16 pixels is hit. A double column counts as hit when any of its superpixels is hit. For every unit it visits, the stream carries one marker bit. The unit's contents follow only when that marker is 1. A host starts a pass with `start`, collects the bits while `sout_valid` is high, and sees `done` when the pass is over.

Top module: `zs_readout`

## Requirements
- R1: While reset is held and after it is released, `sout_valid` and `done` are 0 until `start` is given.
- R2: On the clock edge where `start` is accepted, the block captures all hit flags. Changes on `pix_hit` after that edge have no effect on the stream of that pass. `pix_cnt` must stay stable during the pass.
- R3: Each double column d (columns 2d and 2d+1) first emits one marker bit. The bit is 1 when any pixel in those two columns is hit. A 0 marker is followed directly by the next double column's marker, or by the end of the pass.
- R4: Inside a double column with marker 1, each superpixel s (rows 8s to 8s+7) emits one marker bit. The bit is the OR of its 16 hit flags. A 0 marker skips all of that superpixel's pixels.
- R5: Inside a superpixel with marker 1, each pixel emits its hit flag. A flag of 1 is followed by the pixel's DW-bit counter word, most significant bit first. Pixel (column c, row r) owns `pix_hit[c*NROW+r]` and `pix_cnt[(c*NROW+r)*DW +: DW]`.
- R6: The visiting order is as follows. Double columns go in ascending order. Superpixels go in ascending row order. Within a superpixel, the left column goes first and then the right column, with rows ascending in each.
- R7: The stream starts in the cycle after `start` is accepted. It then delivers exactly one bit per cycle with `sout_valid` held high and no gaps, up to the last bit.
- R8: `done` is high for exactly one cycle, in the cycle right after the last bit, with `sout_valid` low. The captured flags are cleared at that point.
- R9: `start` is ignored while a pass is in progress, including its `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a readout pass (accepted only when idle) |
| pix_hit | input | NCOL*NROW | Hit flag per pixel, index column*NROW+row |
| pix_cnt | input | NCOL*NROW*DW | Counter word per pixel |
| sout_valid | output | 1 | A stream bit is present on `sout_bit` |
| sout_bit | output | 1 | Serial stream bit |
| done | output | 1 | One-cycle end-of-pass pulse |

## Verification
Two situations are hard to reach from the ports. The first is proving that flags are captured rather than followed. To test this, the bench inverts `pix_hit` in the cycle right after `start` is accepted and still expects the stream of the original pattern. The second is a second start request arriving while the block is busy. To test this, the bench holds `start` high into the first stream cycle and then checks that no second pass appears after `done`. Sparse pseudo-random hit patterns, a single hit in the last pixel, and completely empty and completely full matrices drive every skip level, both with the marker set and with it clear.

// File: rtl/zs_pkg.sv
package zs_pkg;

  localparam int SP_W = 2;              // superpixel width in columns
  localparam int SP_H = 8;              // superpixel height in rows
  localparam int SP_N = SP_W * SP_H;    // pixels per superpixel

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COL,
    ST_SP,
    ST_PIX,
    ST_DATA,
    ST_DONE
  } walk_state_e;

  // Flat pixel number for double column dcol, superpixel spix, slot k.
  // Slots 0..7 are the left column, rows ascending; slots 8..15 the right.
  function automatic int pix_index(int dcol, int spix, int k, int nrow);
    return (SP_W * dcol + k / SP_H) * nrow + SP_H * spix + (k % SP_H);
  endfunction

endpackage

// File: rtl/zs_flag_latch.sv
module zs_flag_latch #(
  parameter int NPIX = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            clear,
  input  logic [NPIX-1:0] flags_in,
  output logic [NPIX-1:0] flags_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)     flags_q <= '0;
    else if (load)  flags_q <= flags_in;
    else if (clear) flags_q <= '0;
  end

endmodule

// File: rtl/zs_flag_tree.sv
module zs_flag_tree import zs_pkg::*; #(
  parameter int NCOL = 4,
  parameter int NROW = 16
) (
  input  logic [NCOL*NROW-1:0]                 pix_flags,
  output logic [(NCOL/SP_W)*(NROW/SP_H)-1:0]   sp_flags,
  output logic [(NCOL/SP_W)-1:0]               col_flags
);

  localparam int NDC = NCOL / SP_W;
  localparam int NSP = NROW / SP_H;

  for (genvar d = 0; d < NDC; d++) begin : g_dcol
    for (genvar s = 0; s < NSP; s++) begin : g_sp
      // left column segment OR right column segment
      assign sp_flags[d*NSP+s] =
          (|pix_flags[(SP_W*d)*NROW + SP_H*s +: SP_H]) |
          (|pix_flags[(SP_W*d+1)*NROW + SP_H*s +: SP_H]);
    end
    assign col_flags[d] = |sp_flags[d*NSP +: NSP];
  end

endmodule

// File: rtl/zs_walker.sv
module zs_walker import zs_pkg::*; #(
  parameter int NCOL = 4,
  parameter int NROW = 16,
  parameter int DW   = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [NCOL*NROW-1:0]        pix_flags,
  input  logic [(NCOL/SP_W)*(NROW/SP_H)-1:0] sp_flags,
  input  logic [(NCOL/SP_W)-1:0]      col_flags,
  input  logic [NCOL*NROW*DW-1:0]     pix_cnt,
  output logic                        sout_valid,
  output logic                        sout_bit,
  output logic                        done,
  output logic                        load,
  output logic                        clear,
  output logic                        last_bit,
  output walk_state_e                 state
);

  localparam int NDC  = NCOL / SP_W;
  localparam int NSP  = NROW / SP_H;
  localparam int NPIX = NCOL * NROW;
  localparam int DCW  = (NDC > 1) ? $clog2(NDC) : 1;
  localparam int SPW  = (NSP > 1) ? $clog2(NSP) : 1;
  localparam int KW   = $clog2(SP_N);
  localparam int BW   = (DW > 1) ? $clog2(DW) : 1;
  localparam int PIW  = (NPIX > 1) ? $clog2(NPIX) : 1;
  localparam int SIW  = (NDC*NSP > 1) ? $clog2(NDC*NSP) : 1;
  localparam int DIW  = $clog2(NPIX*DW);

  walk_state_e    st_n;
  logic [DCW-1:0] dc, dc_n;
  logic [SPW-1:0] sp, sp_n;
  logic [KW-1:0]  k, k_n;
  logic [BW-1:0]  b, b_n;

  logic [PIW-1:0] cur_pix;
  logic [SIW-1:0] cur_sp;
  logic [DIW-1:0] cur_bit;
  logic           cflag, sflag, pflag, dbit;
  logic           adv_pix, adv_sp, adv_col;

  always_comb begin
    cur_pix = PIW'(pix_index(int'(dc), int'(sp), int'(k), NROW));
    cur_sp  = SIW'(int'(dc) * NSP + int'(sp));
    cur_bit = DIW'(int'(cur_pix) * DW + int'(b));
    cflag   = col_flags[dc];
    sflag   = sp_flags[cur_sp];
    pflag   = pix_flags[cur_pix];
    dbit    = pix_cnt[cur_bit];
  end

  // next-state walk: a skip at one level cascades into the level above
  always_comb begin
    st_n = state; dc_n = dc; sp_n = sp; k_n = k; b_n = b;
    adv_pix = 1'b0; adv_sp = 1'b0; adv_col = 1'b0;
    unique case (state)
      ST_IDLE: if (start) begin st_n = ST_COL; dc_n = '0; end
      ST_COL:  if (cflag) begin st_n = ST_SP; sp_n = '0; end
               else adv_col = 1'b1;
      ST_SP:   if (sflag) begin st_n = ST_PIX; k_n = '0; end
               else adv_sp = 1'b1;
      ST_PIX:  if (pflag) begin st_n = ST_DATA; b_n = BW'(DW-1); end
               else adv_pix = 1'b1;
      ST_DATA: if (b == '0) adv_pix = 1'b1;
               else b_n = b - 1'b1;
      ST_DONE: st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
    if (adv_pix) begin
      if (k == KW'(SP_N-1)) adv_sp = 1'b1;
      else begin k_n = k + 1'b1; st_n = ST_PIX; end
    end
    if (adv_sp) begin
      if (sp == SPW'(NSP-1)) adv_col = 1'b1;
      else begin sp_n = SPW'(int'(sp) + 1); st_n = ST_SP; end
    end
    if (adv_col) begin
      if (dc == DCW'(NDC-1)) st_n = ST_DONE;
      else begin dc_n = DCW'(int'(dc) + 1); st_n = ST_COL; end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      dc <= '0; sp <= '0; k <= '0; b <= '0;
    end else begin
      state <= st_n;
      dc <= dc_n; sp <= sp_n; k <= k_n; b <= b_n;
    end
  end

  always_comb begin
    sout_valid = (state == ST_COL) || (state == ST_SP) ||
                 (state == ST_PIX) || (state == ST_DATA);
    unique case (state)
      ST_COL:  sout_bit = cflag;
      ST_SP:   sout_bit = sflag;
      ST_PIX:  sout_bit = pflag;
      ST_DATA: sout_bit = dbit;
      default: sout_bit = 1'b0;
    endcase
    done     = (state == ST_DONE);
    load     = (state == ST_IDLE) && start;
    clear    = done;
    last_bit = sout_valid && (st_n == ST_DONE);
  end

endmodule

// File: rtl/zs_readout.sv
module zs_readout import zs_pkg::*; #(
  parameter int NCOL = 4,
  parameter int NROW = 16,
  parameter int DW   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [NCOL*NROW-1:0]    pix_hit,
  input  logic [NCOL*NROW*DW-1:0] pix_cnt,
  output logic                    sout_valid,
  output logic                    sout_bit,
  output logic                    done
);

  localparam int NDC  = NCOL / SP_W;
  localparam int NSP  = NROW / SP_H;
  localparam int NPIX = NCOL * NROW;

  logic [NPIX-1:0]    flags_q;
  logic [NDC*NSP-1:0] sp_flags;
  logic [NDC-1:0]     col_flags;
  logic               load, clear, last_bit;
  walk_state_e        walk_st;

  zs_flag_latch #(.NPIX(NPIX)) u_latch (
    .clk(clk), .rst_n(rst_n), .load(load), .clear(clear),
    .flags_in(pix_hit), .flags_q(flags_q)
  );

  zs_flag_tree #(.NCOL(NCOL), .NROW(NROW)) u_tree (
    .pix_flags(flags_q), .sp_flags(sp_flags), .col_flags(col_flags)
  );

  zs_walker #(.NCOL(NCOL), .NROW(NROW), .DW(DW)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(start),
    .pix_flags(flags_q), .sp_flags(sp_flags), .col_flags(col_flags),
    .pix_cnt(pix_cnt),
    .sout_valid(sout_valid), .sout_bit(sout_bit), .done(done),
    .load(load), .clear(clear), .last_bit(last_bit), .state(walk_st)
  );

endmodule

// File: rtl/zs_readout_chk.sv
module zs_readout_chk import zs_pkg::*; #(
  parameter int NPIX = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            sout_valid,
  input logic            sout_bit,
  input logic            done,
  input logic            last_bit,
  input walk_state_e     state,
  input logic [NPIX-1:0] flags_q
);

  p_flags_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state inside {ST_COL, ST_SP, ST_PIX, ST_DATA}) |=> $stable(flags_q));

  p_col_skip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_COL && !sout_bit) |=> (state == ST_COL || done));

  p_col_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_COL && sout_bit) |=> (state == ST_SP));

  p_sp_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SP && !sout_bit) |=> (state == ST_SP || state == ST_COL || done));

  p_pix_skip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PIX && !sout_bit) |=> (state != ST_DATA));

  p_data_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PIX && sout_bit) |=> (state == ST_DATA));

  p_gapless_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sout_valid && !last_bit) |=> sout_valid);

  p_done_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sout_valid && last_bit) |=> done);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !sout_valid));

  p_done_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !sout_valid);

  p_flags_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (flags_q == '0));

  p_start_in_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> (state == ST_IDLE));

endmodule

bind zs_readout zs_readout_chk #(.NPIX(NPIX)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start),
  .sout_valid(sout_valid), .sout_bit(sout_bit), .done(done),
  .last_bit(last_bit), .state(walk_st), .flags_q(flags_q)
);

// File: tb/zs_readout_test.sv
module zs_readout_test;

  localparam int NCOL = 4;
  localparam int NROW = 16;
  localparam int DW   = 4;
  localparam int NPIX = NCOL * NROW;
  localparam int NDC  = NCOL / 2;
  localparam int NSP  = NROW / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [NPIX-1:0]    pix_hit = '0;
  logic [NPIX*DW-1:0] pix_cnt = '0;
  logic sout_valid, sout_bit, done;

  always #5 clk = ~clk;

  zs_readout #(.NCOL(NCOL), .NROW(NROW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .pix_hit(pix_hit), .pix_cnt(pix_cnt),
    .sout_valid(sout_valid), .sout_bit(sout_bit), .done(done)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    exp_q[$];
  string cur_req = "R1";
  bit    in_frame = 1'b0;
  int    bit_no = 0;
  bit    finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act,
                       input int exp, input string what);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    logic e;
    if (rst_n) begin
      if (sout_valid) begin
        if (exp_q.size() == 0)
          check(1'b0, cur_req, bit_no, -1, "extra stream bit at position");
        else begin
          e = exp_q.pop_front();
          check(sout_bit == e, cur_req, int'(sout_bit), int'(e), "stream bit");
        end
        bit_no++;
        in_frame = 1'b1;
      end else if (done) begin
        in_frame = 1'b0;
      end else if (in_frame) begin
        check(1'b0, "R7", 0, 1, "sout_valid gap inside stream");
      end
    end
  end

  // expected stream built from the requirements
  task automatic push_expected(input logic [NPIX-1:0] hits,
                               input logic [NPIX*DW-1:0] cnt);
    for (int d = 0; d < NDC; d++) begin
      bit cf = |hits[2*d*NROW +: 2*NROW];
      exp_q.push_back(cf);
      if (cf) begin
        for (int s = 0; s < NSP; s++) begin
          bit sf = 1'b0;
          for (int c = 0; c < 2; c++)
            for (int r = 0; r < 8; r++)
              sf |= hits[(2*d+c)*NROW + 8*s + r];
          exp_q.push_back(sf);
          if (sf) begin
            for (int c = 0; c < 2; c++)
              for (int r = 0; r < 8; r++) begin
                int idx = (2*d+c)*NROW + 8*s + r;
                exp_q.push_back(hits[idx]);
                if (hits[idx])
                  for (int bb = DW-1; bb >= 0; bb--)
                    exp_q.push_back(cnt[idx*DW + bb]);
              end
          end
        end
      end
    end
  endtask

  // mode 0: plain, 1: flags flipped after capture, 2: start held while busy
  task automatic run_frame(input logic [NPIX-1:0] hits,
                           input logic [NPIX*DW-1:0] cnt,
                           input string req, input int mode);
    int guard;
    @(negedge clk);
    pix_hit = hits;
    pix_cnt = cnt;
    cur_req = req;
    bit_no  = 0;
    exp_q.delete();
    push_expected(hits, cnt);
    start = 1'b1;
    @(negedge clk);
    if (mode != 2) start = 1'b0;
    if (mode == 1) pix_hit = ~hits;
    if (mode == 2) begin @(negedge clk); start = 1'b0; end
    guard = 0;
    while (!done && guard < 5000) begin @(negedge clk); guard++; end
    check(done == 1'b1, "R8", int'(done), 1, "done reached");
    check(exp_q.size() == 0, "R7", exp_q.size(), 0, "bits still owed at done");
    @(negedge clk);
    check(done == 1'b0, "R8", int'(done), 0, "done width");
    check(sout_valid == 1'b0, (mode == 2) ? "R9" : "R8", int'(sout_valid), 0,
          "valid after done");
    if (mode == 2) begin
      @(negedge clk);
      check(sout_valid == 1'b0, "R9", int'(sout_valid), 0, "no second pass");
    end
    pix_hit = hits;
  endtask

  function automatic logic [NPIX*DW-1:0] ramp_data(input int seed);
    logic [NPIX*DW-1:0] v;
    for (int i = 0; i < NPIX; i++) v[i*DW +: DW] = DW'(i * 7 + seed);
    return v;
  endfunction

  logic [31:0] xs = 32'h1234_5678;
  function automatic logic [31:0] xstep(input logic [31:0] v);
    logic [31:0] t = v;
    t ^= t << 13; t ^= t >> 17; t ^= t << 5;
    return t;
  endfunction

  initial begin
    logic [NPIX-1:0] h;
    repeat (3) @(negedge clk);
    check(sout_valid == 1'b0 && done == 1'b0, "R1",
          int'({sout_valid, done}), 0, "outputs in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(sout_valid == 1'b0 && done == 1'b0, "R1",
          int'({sout_valid, done}), 0, "outputs idle after reset");

    // empty matrix: only column markers
    run_frame('0, ramp_data(1), "R3", 0);
    // full matrix: every marker and every word
    run_frame('1, ramp_data(3), "R5", 0);
    // only the last pixel (column 3, row 15)
    h = '0; h[NPIX-1] = 1'b1;
    run_frame(h, ramp_data(5), "R4", 0);
    // ordering: col0 row0, col1 row3, col2 row9
    h = '0; h[0] = 1'b1; h[1*NROW+3] = 1'b1; h[2*NROW+9] = 1'b1;
    run_frame(h, ramp_data(9), "R6", 0);
    // flags flipped after capture
    h = '0; h[5] = 1'b1; h[3*NROW+12] = 1'b1;
    run_frame(h, ramp_data(2), "R2", 1);
    // start held into the stream
    h = '0; h[NROW+8] = 1'b1;
    run_frame(h, ramp_data(4), "R9", 2);
    // sparse pseudo-random frames
    for (int f = 0; f < 6; f++) begin
      logic [NPIX-1:0] a, b2;
      logic [NPIX*DW-1:0] dd;
      for (int w = 0; w < NPIX/32; w++) begin
        xs = xstep(xs); a[w*32 +: 32] = xs;
        xs = xstep(xs); b2[w*32 +: 32] = xs;
      end
      for (int w = 0; w < NPIX*DW/32; w++) begin
        xs = xstep(xs); dd[w*32 +: 32] = xs;
      end
      run_frame(a & b2 & {NPIX{f[0]}} | (a & b2 & ~{NPIX{f[0]}} & {NPIX/2{2'b01}}),
                dd, "R6", 0);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL R7 watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule